// File: doc/BRIEF.md
# Multi-Size Secure-Aware Translation Lookaside Buffer

This block is a small, fully associative cache of address translations. A lookup supplies a 32-bit virtual address, the current address-space identifier and the security world the processor is running in. One clock later the block returns whether a translation hit, the physical address, the security attribute to attach to the access and the 4-bit domain of the matching entry.

Each entry covers one of four region sizes: 4 KB, 64 KB, 1 MB or 16 MB. An entry is either global or tagged with an address-space identifier, so a context switch needs no flush. Each entry also records the world it was filled in, and it only serves lookups from that world. A page-table walker outside the block writes entries through the fill port. Maintenance inputs clear all entries, the entries of one identifier, or the entries that cover one address.

Top module: `region_tlb`

## Requirements
- R1: The size code of an entry sets which VA bits are compared: 0 = 4 KB (bits 31:12), 1 = 64 KB (31:16), 2 = 1 MB (31:20), 3 = 16 MB (31:24). VA bits below the region size never affect the match.
- R2: On a hit, the PA is the entry's physical base bits above the region size, followed by the lookup VA bits below it. PA bits 11:0 always equal VA bits 11:0.
- R3: A global entry matches under any current ASID. A non-global entry matches only when its stored 8-bit ASID equals the current ASID.
- R4: An entry matches only lookups made from the world it was filled in (`fill_secure_i` equal to `lk_secure_i`).
- R5: In a non-secure lookup (`lk_secure_i`=0), `res_ns_o` is 1 on every hit. In a secure lookup it equals the NS bit stored in the hitting entry.
- R6: A hit returns the 4-bit domain stored in the hitting entry.
- R7: The result is registered. It appears on the clock edge that samples the lookup. When `lk_valid_i` is low, or when nothing matches, the next result has hit, PA, NS, domain and multi-hit all 0.
- R8: A fill writes the lowest-indexed invalid entry. When every entry is valid, the fill writes the entry at a round-robin pointer instead. The pointer starts at 0 after reset and advances by one, wrapping, on each such fill.
- R9: `inv_all_i` clears every entry.
- R10: Invalidate-by-ASID clears only valid non-global entries whose ASID equals `inv_asid_val_i`. Global entries and entries with other ASIDs stay.
- R11: Invalidate-by-VA clears every entry, in either world and under any ASID, whose region covers the given page number.
- R12: A lookup in the same cycle as an invalidate sees the entries as they were before it. In the same cycle, invalidations act on the old contents, a fill writes after them, and the fill picks its victim from the old valid bits.
- R13: When more than one entry matches, the lowest-indexed entry supplies the result and `res_multi_o` is 1.
- R14: After reset every entry is invalid and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Lookup virtual address |
| lk_asid_i | input | 8 | Current address-space identifier |
| lk_secure_i | input | 1 | Processor in secure world |
| res_hit_o | output | 1 | Registered hit |
| res_pa_o | output | 32 | Registered physical address |
| res_ns_o | output | 1 | Registered non-secure attribute |
| res_domain_o | output | 4 | Registered domain |
| res_multi_o | output | 1 | More than one entry matched |
| fill_valid_i | input | 1 | Write one entry |
| fill_vpn_i | input | 20 | Virtual page number (VA 31:12) |
| fill_ppn_i | input | 20 | Physical page number (PA 31:12) |
| fill_size_i | input | 2 | Region size code |
| fill_global_i | input | 1 | Entry is global |
| fill_asid_i | input | 8 | Entry ASID |
| fill_domain_i | input | 4 | Entry domain |
| fill_ns_i | input | 1 | Entry NS attribute |
| fill_secure_i | input | 1 | World the entry belongs to |
| inv_all_i | input | 1 | Invalidate all entries |
| inv_asid_i | input | 1 | Invalidate by ASID |
| inv_asid_val_i | input | 8 | ASID to invalidate |
| inv_va_i | input | 1 | Invalidate by address |
| inv_vpn_i | input | 20 | Page number to invalidate |

## Verification
Directed lookups hit just inside and just outside a 1 MB region. This separates the compared bits from the offset bits. Lookups with a wrong ASID, or from the other world, separate tag matching from world tagging. A non-secure lookup of an entry holding NS=0 shows whether the NS attribute is forced. Overlapping 1 MB and 16 MB entries show which entry wins, and nine fills into eight entries show the replacement order. Random fills of all four sizes into a narrow address window, mixed with lookups and maintenance, produce frequent overlaps and same-cycle interactions, and every result is compared with a reference model.

// File: rtl/region_tlb_pkg.sv
package region_tlb_pkg;
  localparam int VA_W   = 32;
  localparam int PG_LSB = 12;
  localparam int TAG_W  = VA_W - PG_LSB;
  localparam int ASID_W = 8;
  localparam int DOM_W  = 4;

  typedef enum logic [1:0] {
    SZ_4K  = 2'd0,
    SZ_64K = 2'd1,
    SZ_1M  = 2'd2,
    SZ_16M = 2'd3
  } region_size_e;

  typedef struct packed {
    logic               world_sec;
    logic               global;
    logic               ns;
    logic [DOM_W-1:0]   domain;
    logic [ASID_W-1:0]  asid;
    region_size_e       size;
    logic [TAG_W-1:0]   vtag;
    logic [TAG_W-1:0]   ptag;
  } tlb_entry_t;

  // ones over the tag bits compared for a region size
  function automatic logic [TAG_W-1:0] tag_mask(region_size_e s);
    case (s)
      SZ_64K:  tag_mask = {{(TAG_W-4){1'b1}},  4'h0};
      SZ_1M:   tag_mask = {{(TAG_W-8){1'b1}},  8'h0};
      SZ_16M:  tag_mask = {{(TAG_W-12){1'b1}}, 12'h0};
      default: tag_mask = {TAG_W{1'b1}};
    endcase
  endfunction
endpackage

// File: rtl/region_tlb_entry.sv
module region_tlb_entry
  import region_tlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  tlb_entry_t        wr_data_i,
  input  logic [TAG_W-1:0]  lk_tag_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_secure_i,
  input  logic              inv_all_i,
  input  logic              inv_asid_i,
  input  logic [ASID_W-1:0] inv_asid_val_i,
  input  logic              inv_va_i,
  input  logic [TAG_W-1:0]  inv_tag_i,
  output logic              valid_o,
  output logic              match_o,
  output logic [TAG_W-1:0]  ptag_o,
  output region_size_e      size_o,
  output logic              ns_o,
  output logic [DOM_W-1:0]  domain_o
);
  tlb_entry_t       ent_q;
  logic             valid_q;
  logic [TAG_W-1:0] mask;
  logic             kill;

  assign mask = tag_mask(ent_q.size);

  assign match_o = valid_q && (ent_q.world_sec == lk_secure_i)
                && (ent_q.global || (ent_q.asid == lk_asid_i))
                && (((lk_tag_i ^ ent_q.vtag) & mask) == '0);

  assign kill = inv_all_i
             || (inv_asid_i && !ent_q.global && (ent_q.asid == inv_asid_val_i))
             || (inv_va_i && (((inv_tag_i ^ ent_q.vtag) & mask) == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q   <= '0;
      valid_q <= 1'b0;
    end else if (wr_i) begin
      ent_q   <= wr_data_i;
      valid_q <= 1'b1;
    end else if (kill) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign ptag_o   = ent_q.ptag;
  assign size_o   = ent_q.size;
  assign ns_o     = ent_q.ns;
  assign domain_o = ent_q.domain;

  p_fill_sets_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_o);

  p_asid_inv_spares_global_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_asid_i && valid_q && ent_q.global && !inv_all_i && !inv_va_i) |=> valid_o);
endmodule

// File: rtl/region_tlb_victim.sv
module region_tlb_victim #(
  parameter int N_ENTRIES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic                 fill_i,
  output logic [N_ENTRIES-1:0] victim_oh_o
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [IDX_W-1:0]     rr_q;
  logic [N_ENTRIES-1:0] free_oh, rr_oh;
  logic                 found, all_valid;

  always_comb begin
    free_oh = '0;
    found   = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (!valid_i[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    rr_oh = '0;
    rr_oh[rr_q] = 1'b1;
  end

  assign all_valid   = &valid_i;
  assign victim_oh_o = all_valid ? rr_oh : free_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (fill_i && all_valid) begin
      rr_q <= (rr_q == IDX_W'(N_ENTRIES-1)) ? '0 : rr_q + 1'b1;
    end
  end

  p_one_victim_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |-> ($countones(victim_oh_o) == 1));

  p_no_evict_with_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !all_valid) |-> ((victim_oh_o & valid_i) == '0));
endmodule

// File: rtl/region_tlb.sv
module region_tlb
  import region_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VA_W-1:0]   lk_va_i,
  input  logic [ASID_W-1:0] lk_asid_i,
  input  logic              lk_secure_i,
  output logic              res_hit_o,
  output logic [VA_W-1:0]   res_pa_o,
  output logic              res_ns_o,
  output logic [DOM_W-1:0]  res_domain_o,
  output logic              res_multi_o,
  input  logic              fill_valid_i,
  input  logic [TAG_W-1:0]  fill_vpn_i,
  input  logic [TAG_W-1:0]  fill_ppn_i,
  input  logic [1:0]        fill_size_i,
  input  logic              fill_global_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [DOM_W-1:0]  fill_domain_i,
  input  logic              fill_ns_i,
  input  logic              fill_secure_i,
  input  logic              inv_all_i,
  input  logic              inv_asid_i,
  input  logic [ASID_W-1:0] inv_asid_val_i,
  input  logic              inv_va_i,
  input  logic [TAG_W-1:0]  inv_vpn_i
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0] valid_vec, match_vec, victim_oh;
  logic [TAG_W-1:0]     ptag_arr [N_ENTRIES];
  region_size_e         size_arr [N_ENTRIES];
  logic                 ns_arr   [N_ENTRIES];
  logic [DOM_W-1:0]     dom_arr  [N_ENTRIES];
  tlb_entry_t           fill_ent;
  region_size_e         fill_sz;

  assign fill_sz = region_size_e'(fill_size_i);

  always_comb begin
    fill_ent           = '0;
    fill_ent.world_sec = fill_secure_i;
    fill_ent.global    = fill_global_i;
    fill_ent.ns        = fill_ns_i;
    fill_ent.domain    = fill_domain_i;
    fill_ent.asid      = fill_asid_i;
    fill_ent.size      = fill_sz;
    fill_ent.vtag      = fill_vpn_i & tag_mask(fill_sz);
    fill_ent.ptag      = fill_ppn_i;
  end

  region_tlb_victim #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (valid_vec),
    .fill_i      (fill_valid_i),
    .victim_oh_o (victim_oh)
  );

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    region_tlb_entry u_ent (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_i           (fill_valid_i && victim_oh[g]),
      .wr_data_i      (fill_ent),
      .lk_tag_i       (lk_va_i[VA_W-1:PG_LSB]),
      .lk_asid_i      (lk_asid_i),
      .lk_secure_i    (lk_secure_i),
      .inv_all_i      (inv_all_i),
      .inv_asid_i     (inv_asid_i),
      .inv_asid_val_i (inv_asid_val_i),
      .inv_va_i       (inv_va_i),
      .inv_tag_i      (inv_vpn_i),
      .valid_o        (valid_vec[g]),
      .match_o        (match_vec[g]),
      .ptag_o         (ptag_arr[g]),
      .size_o         (size_arr[g]),
      .ns_o           (ns_arr[g]),
      .domain_o       (dom_arr[g])
    );
  end

  // lowest index wins
  logic [IDX_W-1:0] sel;
  logic             any_hit, multi;
  logic [TAG_W-1:0] sel_mask, pa_tag;

  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = N_ENTRIES-1; i >= 0; i--) begin
      if (match_vec[i]) begin
        sel     = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign multi    = ($countones(match_vec) > 1);
  assign sel_mask = tag_mask(size_arr[sel]);
  assign pa_tag   = (ptag_arr[sel] & sel_mask) | (lk_va_i[VA_W-1:PG_LSB] & ~sel_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_hit_o    <= 1'b0;
      res_pa_o     <= '0;
      res_ns_o     <= 1'b0;
      res_domain_o <= '0;
      res_multi_o  <= 1'b0;
    end else if (lk_valid_i && any_hit) begin
      res_hit_o    <= 1'b1;
      res_pa_o     <= {pa_tag, lk_va_i[PG_LSB-1:0]};
      res_ns_o     <= ns_arr[sel] || !lk_secure_i;
      res_domain_o <= dom_arr[sel];
      res_multi_o  <= multi;
    end else begin
      res_hit_o    <= 1'b0;
      res_pa_o     <= '0;
      res_ns_o     <= 1'b0;
      res_domain_o <= '0;
      res_multi_o  <= 1'b0;
    end
  end

  p_nonsecure_forced_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && !lk_secure_i) |=> (!res_hit_o || res_ns_o));

  p_offset_passthru_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i |=> (!res_hit_o || (res_pa_o[PG_LSB-1:0] == $past(lk_va_i[PG_LSB-1:0]))));

  p_idle_no_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> (!res_hit_o && !res_multi_o));

  p_inv_all_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !fill_valid_i) |=> (valid_vec == '0));

  p_multi_needs_hit_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_multi_o |-> res_hit_o);
endmodule

// File: tb/region_tlb_test.sv
module region_tlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid_i, lk_secure_i;
  logic [31:0] lk_va_i;
  logic [7:0]  lk_asid_i;
  logic        res_hit_o, res_ns_o, res_multi_o;
  logic [31:0] res_pa_o;
  logic [3:0]  res_domain_o;
  logic        fill_valid_i, fill_global_i, fill_ns_i, fill_secure_i;
  logic [19:0] fill_vpn_i, fill_ppn_i, inv_vpn_i;
  logic [1:0]  fill_size_i;
  logic [7:0]  fill_asid_i, inv_asid_val_i;
  logic [3:0]  fill_domain_i;
  logic        inv_all_i, inv_asid_i, inv_va_i;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  region_tlb #(.N_ENTRIES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid_i), .lk_va_i(lk_va_i), .lk_asid_i(lk_asid_i), .lk_secure_i(lk_secure_i),
    .res_hit_o(res_hit_o), .res_pa_o(res_pa_o), .res_ns_o(res_ns_o),
    .res_domain_o(res_domain_o), .res_multi_o(res_multi_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_size_i(fill_size_i), .fill_global_i(fill_global_i), .fill_asid_i(fill_asid_i),
    .fill_domain_i(fill_domain_i), .fill_ns_i(fill_ns_i), .fill_secure_i(fill_secure_i),
    .inv_all_i(inv_all_i), .inv_asid_i(inv_asid_i), .inv_asid_val_i(inv_asid_val_i),
    .inv_va_i(inv_va_i), .inv_vpn_i(inv_vpn_i)
  );

  // reference model
  bit          m_v [N];
  bit          m_sec [N], m_glob [N], m_ns [N];
  logic [3:0]  m_dom [N];
  logic [7:0]  m_asid [N];
  logic [1:0]  m_size [N];
  logic [19:0] m_vtag [N], m_ptag [N];
  int          m_rr = 0;

  function automatic logic [19:0] bmask(logic [1:0] s);
    return 20'hFFFFF << (int'(s) * 4);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    lk_valid_i = 0; lk_va_i = 0; lk_asid_i = 0; lk_secure_i = 0;
    fill_valid_i = 0; fill_vpn_i = 0; fill_ppn_i = 0; fill_size_i = 0;
    fill_global_i = 0; fill_asid_i = 0; fill_domain_i = 0; fill_ns_i = 0; fill_secure_i = 0;
    inv_all_i = 0; inv_asid_i = 0; inv_asid_val_i = 0; inv_va_i = 0; inv_vpn_i = 0;
  endtask

  // one clock: expected from pre-edge model, update model, compare after edge
  task automatic step(string req);
    int first = -1;
    int cnt = 0;
    bit kill [N];
    int vic = -1;
    bit full = 1;
    logic        e_hit, e_ns, e_multi;
    logic [31:0] e_pa;
    logic [3:0]  e_dom;
    logic [19:0] mk;
    for (int i = 0; i < N; i++) begin
      mk = bmask(m_size[i]);
      if (m_v[i] && m_sec[i] == lk_secure_i && (m_glob[i] || m_asid[i] == lk_asid_i)
          && ((lk_va_i[31:12] & mk) == (m_vtag[i] & mk))) begin
        if (first < 0) first = i;
        cnt++;
      end
    end
    e_hit = lk_valid_i && cnt > 0;
    e_multi = lk_valid_i && cnt > 1;
    e_pa = 0; e_ns = 0; e_dom = 0;
    if (e_hit) begin
      mk = bmask(m_size[first]);
      e_pa = {(m_ptag[first] & mk) | (lk_va_i[31:12] & ~mk), lk_va_i[11:0]};
      e_ns = !lk_secure_i || m_ns[first];
      e_dom = m_dom[first];
    end
    for (int i = 0; i < N; i++) begin
      mk = bmask(m_size[i]);
      kill[i] = inv_all_i || (inv_asid_i && !m_glob[i] && m_asid[i] == inv_asid_val_i)
             || (inv_va_i && ((inv_vpn_i & mk) == (m_vtag[i] & mk)));
      if (!m_v[i]) full = 0;
      if (!m_v[i] && vic < 0) vic = i;
    end
    if (full) vic = m_rr;
    for (int i = 0; i < N; i++) if (kill[i]) m_v[i] = 0;
    if (fill_valid_i) begin
      m_v[vic] = 1; m_sec[vic] = fill_secure_i; m_glob[vic] = fill_global_i;
      m_ns[vic] = fill_ns_i; m_dom[vic] = fill_domain_i; m_asid[vic] = fill_asid_i;
      m_size[vic] = fill_size_i; m_vtag[vic] = fill_vpn_i; m_ptag[vic] = fill_ppn_i;
      if (full) m_rr = (m_rr + 1) % N;
    end
    @(posedge clk);
    @(negedge clk);
    chk({req, " hit"}, 32'(res_hit_o), 32'(e_hit));
    chk({req, " pa"}, res_pa_o, e_pa);
    chk({req, " ns"}, 32'(res_ns_o), 32'(e_ns));
    chk({req, " domain"}, 32'(res_domain_o), 32'(e_dom));
    chk({req, " multi"}, 32'(res_multi_o), 32'(e_multi));
    clr();
  endtask

  task automatic look(logic [31:0] va, logic [7:0] asid, logic sec, string req);
    lk_valid_i = 1; lk_va_i = va; lk_asid_i = asid; lk_secure_i = sec;
    step(req);
  endtask

  task automatic fill(logic [19:0] vpn, logic [19:0] ppn, logic [1:0] sz, logic glob,
                      logic [7:0] asid, logic [3:0] dom, logic ns, logic sec);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_ppn_i = ppn; fill_size_i = sz;
    fill_global_i = glob; fill_asid_i = asid; fill_domain_i = dom;
    fill_ns_i = ns; fill_secure_i = sec;
    step("R8 fill");
  endtask

  task automatic wipe();
    inv_all_i = 1;
    step("R9 inv all");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_7a1b));
    clr();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_sec[i] = 0; m_glob[i] = 0; m_ns[i] = 0;
      m_dom[i] = 0; m_asid[i] = 0; m_size[i] = 0; m_vtag[i] = 0; m_ptag[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R14 reset hit", 32'(res_hit_o), 0);
    chk("R14 reset pa", res_pa_o, 0);
    rst_n = 1;
    @(negedge clk);
    look(32'h1230_0000, 8'd5, 1'b1, "R14 empty lookup");
    chk("R14 no entries", 32'(res_hit_o), 0);

    // 1 MB secure entry, ASID 5
    fill(20'h12300, 20'h45600, 2'd2, 1'b0, 8'd5, 4'd9, 1'b1, 1'b1);
    look(32'h123A_BCDE, 8'd5, 1'b1, "R1 R2 R6 inside");
    chk("R2 pa", res_pa_o, 32'h456A_BCDE);
    chk("R6 domain", 32'(res_domain_o), 9);
    chk("R5 secure ns from entry", 32'(res_ns_o), 1);
    look(32'h1240_0000, 8'd5, 1'b1, "R1 outside");
    chk("R1 outside miss", 32'(res_hit_o), 0);
    look(32'h1230_0000, 8'd6, 1'b1, "R3 other asid");
    chk("R3 asid miss", 32'(res_hit_o), 0);
    look(32'h1230_0000, 8'd5, 1'b0, "R4 other world");
    chk("R4 world miss", 32'(res_hit_o), 0);

    // non-secure global 4 KB entry, stored NS=0
    fill(20'h00001, 20'h00099, 2'd0, 1'b1, 8'd0, 4'd2, 1'b0, 1'b0);
    look(32'h0000_1123, 8'd77, 1'b0, "R3 R5 global nonsecure");
    chk("R5 forced ns", 32'(res_ns_o), 1);
    chk("R3 global pa", res_pa_o, 32'h0009_9123);

    // 16 MB secure global overlapping the 1 MB entry
    fill(20'h12000, 20'hAB000, 2'd3, 1'b1, 8'd0, 4'd3, 1'b0, 1'b1);
    look(32'h1230_0010, 8'd5, 1'b1, "R13 overlap");
    chk("R13 multi", 32'(res_multi_o), 1);
    chk("R13 lowest wins", res_pa_o, 32'h4560_0010);
    look(32'h12F0_0010, 8'd5, 1'b1, "R1 16MB only");
    chk("R1 16MB pa", res_pa_o, 32'hABF0_0010);

    // lookup together with invalidate-all
    lk_valid_i = 1; lk_va_i = 32'h1230_0000; lk_asid_i = 8'd5; lk_secure_i = 1; inv_all_i = 1;
    step("R12 same cycle");
    chk("R12 pre-inv hit", 32'(res_hit_o), 1);
    look(32'h1230_0000, 8'd5, 1'b1, "R9 after inv");
    chk("R9 cleared", 32'(res_hit_o), 0);

    // nine fills into eight entries
    for (int i = 0; i < 9; i++)
      fill(20'h40000 + 20'(i), 20'h80000 + 20'(i), 2'd0, 1'b1, 8'd0, 4'(i), 1'b0, 1'b1);
    look(32'h4000_0000, 8'd0, 1'b1, "R8 evicted 0");
    chk("R8 entry0 evicted", 32'(res_hit_o), 0);
    look(32'h4000_1000, 8'd0, 1'b1, "R8 kept 1");
    chk("R8 entry1 kept", 32'(res_hit_o), 1);
    fill(20'h40009, 20'h80009, 2'd0, 1'b1, 8'd0, 4'd9, 1'b0, 1'b1);
    look(32'h4000_1000, 8'd0, 1'b1, "R8 evicted 1");
    chk("R8 rr advanced", 32'(res_hit_o), 0);

    // invalidate by ASID
    wipe();
    fill(20'h50000, 20'h11000, 2'd0, 1'b0, 8'd3, 4'd1, 1'b0, 1'b1);
    fill(20'h50001, 20'h11001, 2'd0, 1'b1, 8'd3, 4'd1, 1'b0, 1'b1);
    fill(20'h50002, 20'h11002, 2'd0, 1'b0, 8'd4, 4'd1, 1'b0, 1'b1);
    inv_asid_i = 1; inv_asid_val_i = 8'd3;
    step("R10 inv asid");
    look(32'h5000_0000, 8'd3, 1'b1, "R10 nonglobal");
    chk("R10 asid entry gone", 32'(res_hit_o), 0);
    look(32'h5000_1000, 8'd3, 1'b1, "R10 global");
    chk("R10 global kept", 32'(res_hit_o), 1);
    look(32'h5000_2000, 8'd4, 1'b1, "R10 other asid");
    chk("R10 other asid kept", 32'(res_hit_o), 1);

    // invalidate by VA
    wipe();
    fill(20'h60010, 20'h22010, 2'd1, 1'b1, 8'd0, 4'd5, 1'b0, 1'b1);
    fill(20'h60013, 20'h33013, 2'd0, 1'b0, 8'd7, 4'd6, 1'b0, 1'b0);
    fill(20'h60020, 20'h44020, 2'd0, 1'b1, 8'd0, 4'd7, 1'b0, 1'b1);
    inv_va_i = 1; inv_vpn_i = 20'h60013;
    step("R11 inv va");
    look(32'h6001_5000, 8'd0, 1'b1, "R11 64K");
    chk("R11 64K gone", 32'(res_hit_o), 0);
    look(32'h6001_3000, 8'd7, 1'b0, "R11 4K");
    chk("R11 4K gone", 32'(res_hit_o), 0);
    look(32'h6002_0000, 8'd0, 1'b1, "R11 other");
    chk("R11 other kept", 32'(res_hit_o), 1);

    // random mix in a narrow window so regions overlap
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom % 100);
      lk_valid_i = ($urandom % 8) != 0;
      lk_va_i = 32'h7000_0000 | ($urandom & 32'h00FF_FFFF);
      lk_asid_i = 8'($urandom % 3);
      lk_secure_i = 1'($urandom);
      if (op < 30) begin
        fill_valid_i = 1;
        fill_vpn_i = 20'h70000 | 20'($urandom & 32'h00FFF);
        fill_ppn_i = 20'($urandom);
        fill_size_i = 2'($urandom);
        fill_global_i = ($urandom % 4) == 0;
        fill_asid_i = 8'($urandom % 3);
        fill_domain_i = 4'($urandom);
        fill_ns_i = 1'($urandom);
        fill_secure_i = 1'($urandom);
      end
      if (op >= 30 && op < 33) inv_all_i = 1;
      if (op >= 33 && op < 38) begin inv_asid_i = 1; inv_asid_val_i = 8'($urandom % 3); end
      if (op >= 38 && op < 44) begin inv_va_i = 1; inv_vpn_i = 20'h70000 | 20'($urandom & 32'h00FFF); end
      step("R7 random");
    end
    finish_run();
  end
endmodule